// File: doc/BRIEF.md
# SIMD Left Shift-Insert Unit

This block shifts every lane of a 128-bit vector left by an immediate amount and writes the result into a register. The lanes can be 8, 16, 32 or 64 bits wide. Bits that move past the top of a lane are dropped and never spill into the lane above.

There are four modes. Plain mode returns the shifted lanes. Insert mode also returns the shifted lanes, but it fills the vacated low bits of each lane from the old destination lane. The two widening modes take half-width source elements, extend them to twice their width (one with zeros, one with the sign bit), and then shift them. A 64/128-bit flag sets the operand width. For plain and insert it clears the upper half of the result. For the widening modes it picks which half of the source the elements come from.

A one-cycle start pulse captures the result. The valid strobe goes high on the next cycle for that one cycle only.

Top module: `simd_shl_ins`

## Requirements
- R1: `size_i` sets the lane width to 8 << `size_i` bits (0 → 8, 1 → 16, 2 → 32, 3 → 64). A 128-bit vector then holds 16 >> `size_i` lanes, with lane k at bits [k*W +: W].
- R2: The shift amount is `imm_i` modulo the lane width, taken from the low log2(W) bits of `imm_i`. A canonical immediate of W + s therefore shifts by s.
- R3: When `mode_i` = 0 (plain), each lane is source lane << shift. Bits shifted past bit W-1 are discarded and do not reach the next lane.
- R4: When `mode_i` = 1 (insert), each lane is (source lane << shift) OR (destination lane AND a mask of `shift` low ones).
- R5: In insert mode a shift of zero gives an all-zero mask, so the source fully replaces the destination lane.
- R6: For plain and insert, `q128_i` = 0 forces result bits [127:64] to zero. `q128_i` = 1 keeps all lanes.
- R7: `mode_i` = 2 zero-extends and `mode_i` = 3 sign-extends. Each of the 8 >> `size_i` source elements of width W is extended to 2W and then shifted left by `imm_i` mod W. Element e goes to result bits [e*2W +: 2W].
- R8: In the widening modes, `q128_i` = 0 takes the elements from source bits [63:0] and `q128_i` = 1 takes them from source bits [127:64].
- R9: In the widening modes, `size_i` = 3 produces an all-zero result.
- R10: A high `start_i` at a rising edge loads the result, and `valid_o` is high for exactly the following cycle. Without `start_i`, `res_o` holds its value and `valid_o` is low.
- R11: While `rst_ni` is low, `res_o` and `valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture pulse |
| src_i | input | 128 | Source vector |
| dst_i | input | 128 | Old destination vector (insert mode) |
| size_i | input | 2 | Lane size code |
| imm_i | input | 7 | Shift immediate |
| mode_i | input | 2 | 0 plain, 1 insert, 2 widen zero, 3 widen sign |
| q128_i | input | 1 | 1 = 128-bit form, 0 = 64-bit form |
| res_o | output | 128 | Registered result vector |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The hardest cases to reach are at the lane edges. Insert mode with a shift of zero has to replace the destination lane completely, and a sign-extended element with its top bit set must not leak into the neighbouring lane when the shift is at its maximum. Directed vectors use alternating 0x80 and all-ones patterns at the smallest and largest shift for every size, and cover both halves in the widening modes. After that, a long stream of random operands, immediates and start patterns is compared every clock against a bit-level model.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN   = 2'd0,
    MODE_INSERT  = 2'd1,
    MODE_WIDEN_U = 2'd2,
    MODE_WIDEN_S = 2'd3
  } sli_mode_e;

  function automatic logic is_widen(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/sli_lane.sv
module sli_lane #(
  parameter int W = 8,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   src_i,
  input  logic [W-1:0]   dst_i,
  input  logic [SHW-1:0] sh_i,
  input  logic           ins_i,
  output logic [W-1:0]   res_o
);
  logic [W-1:0] keep_mask;

  // low sh_i ones; zero when sh_i == 0
  assign keep_mask = ~({W{1'b1}} << sh_i);
  assign res_o     = (src_i << sh_i) | (ins_i ? (dst_i & keep_mask) : '0);
endmodule

// File: rtl/sli_widen_lane.sv
module sli_widen_lane #(
  parameter int SW = 8,
  localparam int SHW = $clog2(SW),
  localparam int DW  = 2 * SW
) (
  input  logic [SW-1:0]  src_i,
  input  logic           sgn_i,
  input  logic [SHW-1:0] sh_i,
  output logic [DW-1:0]  res_o
);
  logic [DW-1:0] ext;

  assign ext   = {{SW{sgn_i & src_i[SW-1]}}, src_i};
  assign res_o = ext << sh_i;
endmodule

// File: rtl/sli_sel.sv
module sli_sel
  import simd_shl_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int NSZ   = 4,
  localparam int HALF_W = VEC_W / 2
) (
  input  logic [NSZ-1:0][VEC_W-1:0] pi_v_i,
  input  logic [NSZ-1:0][VEC_W-1:0] wd_v_i,
  input  logic [1:0]                size_i,
  input  logic [1:0]                mode_i,
  input  logic                      q128_i,
  output logic [VEC_W-1:0]          res_o
);
  always_comb begin
    if (is_widen(mode_i)) begin
      res_o = wd_v_i[size_i];
    end else begin
      res_o = pi_v_i[size_i];
      if (!q128_i) res_o[VEC_W-1:HALF_W] = '0;
    end
  end
endmodule

// File: rtl/simd_shl_ins.sv
module simd_shl_ins
  import simd_shl_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int IMM_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [1:0]       size_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       mode_i,
  input  logic             q128_i,
  output logic [VEC_W-1:0] res_o,
  output logic             valid_o
);
  localparam int NSZ    = 4;
  localparam int HALF_W = VEC_W / 2;

  logic [NSZ-1:0][VEC_W-1:0] pi_v;
  logic [NSZ-1:0][VEC_W-1:0] wd_v;
  logic [VEC_W-1:0]          res_d, res_q;
  logic                      valid_q;
  logic [HALF_W-1:0]         src_half;
  logic                      unused_imm;

  assign unused_imm = ^imm_i;
  assign src_half   = q128_i ? src_i[VEC_W-1:HALF_W] : src_i[HALF_W-1:0];

  for (genvar gs = 0; gs < NSZ; gs++) begin : g_sz
    localparam int LW  = 8 << gs;
    localparam int LN  = VEC_W / LW;
    localparam int SHW = $clog2(LW);

    for (genvar gl = 0; gl < LN; gl++) begin : g_ln
      sli_lane #(.W(LW)) u_lane (
        .src_i (src_i[gl*LW +: LW]),
        .dst_i (dst_i[gl*LW +: LW]),
        .sh_i  (imm_i[SHW-1:0]),
        .ins_i (mode_i == MODE_INSERT),
        .res_o (pi_v[gs][gl*LW +: LW])
      );
    end

    if (gs < NSZ - 1) begin : g_wd
      localparam int WN = HALF_W / LW;
      for (genvar gl = 0; gl < WN; gl++) begin : g_el
        sli_widen_lane #(.SW(LW)) u_wlane (
          .src_i (src_half[gl*LW +: LW]),
          .sgn_i (mode_i == MODE_WIDEN_S),
          .sh_i  (imm_i[SHW-1:0]),
          .res_o (wd_v[gs][gl*2*LW +: 2*LW])
        );
      end
    end else begin : g_nowd
      assign wd_v[gs] = '0;
    end
  end

  sli_sel #(.VEC_W(VEC_W), .NSZ(NSZ)) u_sel (
    .pi_v_i (pi_v),
    .wd_v_i (wd_v),
    .size_i (size_i),
    .mode_i (mode_i),
    .q128_i (q128_i),
    .res_o  (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) res_q <= res_d;
    end
  end

  assign res_o   = res_q;
  assign valid_o = valid_q;

  // R10
  valid_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  // R10
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!valid_o && $stable(res_o)));
  // R6
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !q128_i && !mode_i[1]) |=> (res_o[VEC_W-1:HALF_W] == '0));
  // R4
  insert_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == MODE_INSERT && size_i == 2'd0 && imm_i[2:0] != 3'd0)
      |=> (res_o[0] == $past(dst_i[0])));
  // R7
  widen_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == MODE_WIDEN_S && size_i == 2'd0 && imm_i[2:0] == 3'd0 && !q128_i)
      |=> (res_o[15:8] == {8{$past(src_i[7])}}));
  // R9
  widen_wide_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i[1] && size_i == 2'd3) |=> (res_o == '0));
endmodule

// File: tb/tb_simd_shl_ins.sv
module tb_simd_shl_ins;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] src = '0, dst = '0;
  logic [1:0]   size = '0, mode = '0;
  logic [6:0]   imm = '0;
  logic         q128 = 1'b0;
  logic [127:0] res;
  logic         valid;

  logic [127:0] exp_res;
  logic         exp_val;
  int nvec = 0, nfail = 0;

  always #10 clk = ~clk;

  simd_shl_ins dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_i(src), .dst_i(dst),
    .size_i(size), .imm_i(imm), .mode_i(mode), .q128_i(q128),
    .res_o(res), .valid_o(valid)
  );

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] d,
                                         input int sz, input int im, input int md,
                                         input bit q);
    logic [127:0] o = '0;
    int lw = 8 << sz;
    int sh = im % lw;
    if (md < 2) begin
      for (int i = 0; i < 128; i++) begin
        int b = i % lw;
        if (b >= sh) o[i] = s[i - sh];
        else if (md == 1) o[i] = d[i];
      end
      if (!q) o[127:64] = '0;
    end else if (sz < 3) begin
      int base = q ? 64 : 0;
      for (int e = 0; e < (8 >> sz); e++) begin
        for (int b = 0; b < 2 * lw; b++) begin
          int p = b - sh;
          logic v;
          if (p < 0) v = 1'b0;
          else if (p < lw) v = s[base + e*lw + p];
          else v = (md == 3) ? s[base + e*lw + lw - 1] : 1'b0;
          o[e*2*lw + b] = v;
        end
      end
    end
    return o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_res <= '0;
      exp_val <= 1'b0;
    end else begin
      exp_val <= start;
      if (start) exp_res <= model(src, dst, size, imm, mode, q128);
    end
  end

  task automatic check(input string req);
    nvec++;
    if (res !== exp_res || valid !== exp_val) begin
      nfail++;
      $display("FAIL %s res=%h exp=%h valid=%b exp=%b", req, res, exp_res, valid, exp_val);
    end
  endtask

  task automatic apply(input bit st, input logic [127:0] s, input logic [127:0] d,
                       input int sz, input int im, input int md, input bit q,
                       input string req);
    start = st; src = s; dst = d; size = 2'(sz); imm = 7'(im); mode = 2'(md); q128 = q;
    @(negedge clk);
    check(req);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  localparam logic [127:0] P80 = {16{8'h80}};
  localparam logic [127:0] PFF = {128{1'b1}};
  localparam logic [127:0] PA5 = {16{8'hA5}};

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release");
    // R3 plain, lane overflow discarded; R1 all sizes
    for (int sz = 0; sz < 4; sz++) begin
      apply(1, P80, PA5, sz, (8 << sz) + 1, 0, 1, "R3 R1 plain shift1");
      apply(1, PFF, PA5, sz, 2 * (8 << sz) - 1, 0, 1, "R3 R1 plain max shift");
    end
    // R2 non-canonical immediate
    apply(1, PA5, '0, 0, 3, 0, 1, "R2 imm mod width");
    apply(1, PA5, '0, 0, 11, 0, 1, "R2 canonical imm");
    // R4 insert
    for (int sz = 0; sz < 4; sz++)
      apply(1, PFF, PA5, sz, (8 << sz) + 5, 1, 1, "R4 insert merge");
    // R5 insert zero shift
    for (int sz = 0; sz < 4; sz++)
      apply(1, P80, PFF, sz, 8 << sz, 1, 1, "R5 insert shift0 replaces");
    // R6 64-bit form
    apply(1, PFF, PFF, 1, 18, 1, 0, "R6 insert upper zero");
    apply(1, PFF, PFF, 3, 64, 0, 0, "R6 plain upper zero");
    // R7 widen zero/sign, R8 halves
    for (int sz = 0; sz < 3; sz++) begin
      apply(1, P80, '0, sz, 8 << sz, 2, 0, "R7 widen zero");
      apply(1, P80, '0, sz, 8 << sz, 3, 0, "R7 widen sign");
      apply(1, {PA5[127:64], P80[63:0]}, '0, sz, 2 * (8 << sz) - 1, 3, 1, "R8 widen upper half");
      apply(1, {PA5[127:64], P80[63:0]}, '0, sz, 2 * (8 << sz) - 1, 3, 0, "R8 widen lower half");
    end
    // R9
    apply(1, PFF, PFF, 3, 70, 3, 1, "R9 widen size3 zero");
    apply(1, PFF, PFF, 3, 70, 2, 0, "R9 widen size3 zero");
    // R10 hold and pulse
    apply(1, PA5, '0, 0, 9, 0, 1, "R10 start");
    apply(0, PFF, PFF, 2, 40, 1, 1, "R10 valid pulse");
    apply(0, '0, '0, 0, 0, 0, 0, "R10 hold");
    apply(1, PFF, '0, 1, 17, 0, 1, "R10 back to back a");
    apply(1, P80, '0, 2, 33, 0, 1, "R10 back to back b");
    // random
    for (int n = 0; n < 4000; n++)
      apply(($urandom % 4) != 0, rnd128(), rnd128(), $urandom % 4, $urandom % 128,
            $urandom % 4, $urandom % 2, "R1 R3 R4 R7 random");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog res=%h exp=%h", res, exp_res);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule